// File: doc/BRIEF.md
# Pinnable Translation Lookaside Buffer

This block is the translation cache of a device-side address translation unit. It keeps a small, fully associative set of entries. Each entry pairs a tag word (virtual page start, page size code, valid bit) with a data word (physical page base plus attribute bits). A lookup port turns a 32-bit device address into a hit flag and a physical address one cycle later. Filling the entries from page tables is the job of software, which works through a register-write port. This block does no table walking of its own.

Replacement is steered by two software-visible indices. A base index splits the entries: slots below it are pinned, and slots from it up to the entry count can be replaced. A victim index names the next slot to fill. Software stages a tag word and a data word, then issues a load. An ordinary load fills the victim slot. A pinned load fills the slot at the base index and moves the boundary up. Because the read-back outputs always show the entry at the victim index, writing the victim field lets software inspect any slot. Single entries can be invalidated by address, and a global flush clears every entry and both indices.

The entry count is a parameter and may only be 8 or 32. Elaboration stops on any other value.

Top module: `pinned_tlb`

## Requirements
- R1: After reset every entry is zero and invalid, both indices are zero, `lock_word` and both read-back outputs are zero, and no lookup hits.
- R2: A lock-register write (`wr_sel`=0) loads the base index from `wr_data[14:10]` and the victim index from `wr_data[8:4]`. `lock_word` shows the base at bits 14:10 with its sixth bit at 15, and the victim at bits 8:4 with its sixth bit at 9. All other bits of `lock_word` read zero.
- R3: `wr_sel`=1 stages the tag word and `wr_sel`=2 stages the data word. The tag word holds the valid bit at bit 2 and the page size code at bits 1:0. A load (`wr_sel`=3) copies both staged words into the chosen slot. `rd_cam` and `rd_ram` show the entry at the victim index, or zero when the victim index is not below the entry count.
- R4: An ordinary load (`wr_data[0]`=0) fills the victim slot. The victim index then increments, and it returns to the base index when it reaches the entry count. The load is refused, with no state change, when the victim index is not below the entry count.
- R5: A pinned load (`wr_data[0]`=1) fills the slot at the base index. Afterwards the base index is one higher and the victim index equals the new base. The load is refused, with no state change, when the base index is not below the entry count.
- R6: A global flush (`wr_sel`=5) zeroes every entry and sets the base and victim indices to zero.
- R7: Page size codes are 0 = 1 MB, 1 = 64 KB, 2 = 4 KB and 3 = 16 MB. A valid entry matches an address when the address lies within [start, start + page bytes), where start is the tag with the bits below the page size cleared. On a hit, `lk_pa` is the data word above the page size combined with the address bits below it. On a miss, `lk_pa` is zero.
- R8: A lookup result appears on the cycle after `lk_addr` is presented. When several entries match, the lowest index wins. Entries with the valid bit clear never hit.
- R9: A flush by address (`wr_sel`=4, address on `wr_data`) clears the valid bit of the lowest-indexed valid entry that matches, and touches no other entry.
- R10: Command codes 6 and 7 change no entry, no index and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command strobe |
| wr_sel | input | 3 | Command code |
| wr_data | input | 32 | Command operand |
| lk_addr | input | 32 | Device address to translate |
| lk_hit | output | 1 | Registered hit flag |
| lk_pa | output | 32 | Registered physical address |
| lock_word | output | 32 | Current base and victim indices |
| rd_cam | output | 32 | Tag word of the entry at the victim index |
| rd_ram | output | 32 | Data word of the entry at the victim index |

## Verification
The bench builds the block with 8 entries. At that size the victim wrap, a fully pinned buffer and a victim index past the end are all reached within a few dozen commands. Random streams of loads, pins, flushes and lock writes over a 64 MB window mix all four page sizes, so overlapping entries and lowest-index priority occur often. Those streams are checked against a reference model that tests range membership with wide arithmetic instead of masks.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;
  localparam int LOCK_FW  = 5;
  localparam int IDX_W    = LOCK_FW + 1;
  localparam int BASE_LSB = 10;
  localparam int VICT_LSB = 4;
  localparam int VLD_BIT  = 2;

  typedef enum logic [2:0] {
    CMD_LOCK     = 3'd0,
    CMD_TAG      = 3'd1,
    CMD_DATA     = 3'd2,
    CMD_LOAD     = 3'd3,
    CMD_KILL_ONE = 3'd4,
    CMD_KILL_ALL = 3'd5
  } cmd_e;

  // high bits that identify a page of the given size code
  function automatic logic [31:0] page_mask(input logic [1:0] code);
    case (code)
      2'd0:    page_mask = 32'hFFF0_0000;
      2'd1:    page_mask = 32'hFFFF_0000;
      2'd2:    page_mask = 32'hFFFF_F000;
      default: page_mask = 32'hFF00_0000;
    endcase
  endfunction

  function automatic logic entry_hit(input logic [31:0] tag, input logic [31:0] addr);
    entry_hit = tag[VLD_BIT] && (((tag ^ addr) & page_mask(tag[1:0])) == 32'd0);
  endfunction

  function automatic logic [31:0] xlate(input logic [31:0] tag, input logic [31:0] dat,
                                        input logic [31:0] addr);
    logic [31:0] m;
    m = page_mask(tag[1:0]);
    xlate = (dat & m) | (addr & ~m);
  endfunction
endpackage

// File: rtl/tlbv_victim.sv
module tlbv_victim
  import tlbv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock_we,
  input  logic [LOCK_FW-1:0] lock_base,
  input  logic [LOCK_FW-1:0] lock_vict,
  input  logic               ld_req,
  input  logic               ld_pres,
  input  logic               clr_all,
  output logic [IDX_W-1:0]   base_q,
  output logic [IDX_W-1:0]   vict_q,
  output logic               ld_ok,
  output logic [IDX_W-1:0]   ld_slot
);
  localparam logic [IDX_W-1:0] NCNT = IDX_W'(N);

  logic             pres_room, norm_room;
  logic [IDX_W-1:0] vict_inc, base_inc;

  assign pres_room = base_q < NCNT;
  assign norm_room = vict_q < NCNT;
  assign ld_ok     = ld_req && (ld_pres ? pres_room : norm_room);
  assign ld_slot   = ld_pres ? base_q : vict_q;
  assign vict_inc  = vict_q + IDX_W'(1);
  assign base_inc  = base_q + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      vict_q <= '0;
    end else if (clr_all) begin
      base_q <= '0;
      vict_q <= '0;
    end else if (lock_we) begin
      base_q <= {1'b0, lock_base};
      vict_q <= {1'b0, lock_vict};
    end else if (ld_ok) begin
      if (ld_pres) begin
        base_q <= base_inc;
        vict_q <= base_inc;
      end else begin
        vict_q <= (vict_inc == NCNT) ? base_q : vict_inc;
      end
    end
  end

  a_r5_pin_moves_base: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ok && ld_pres) |=> (base_q == $past(base_q) + IDX_W'(1)) && (vict_q == base_q));
  a_r5_refused_load_still: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && !ld_ok && !clr_all && !lock_we) |=> $stable(base_q) && $stable(vict_q));
  a_r4_victim_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ok && !ld_pres) |=> (vict_q == $past(vict_q) + IDX_W'(1)) || (vict_q == base_q));
  a_r6_indices_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (base_q == '0) && (vict_q == '0));
endmodule

// File: rtl/tlbv_first.sv
module tlbv_first #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlbv_store.sv
module tlbv_store
  import tlbv_pkg::*;
#(
  parameter int N  = 8,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  logic [31:0]   wr_tag,
  input  logic [31:0]   wr_dat,
  input  logic [N-1:0]  kill,
  input  logic          clr_all,
  input  logic [31:0]   lk_addr,
  input  logic [31:0]   fl_addr,
  input  logic [N-1:0]  lk_grant,
  input  logic          rd_ok,
  input  logic [SW-1:0] rd_idx,
  output logic [N-1:0]  lk_match,
  output logic [N-1:0]  fl_match,
  output logic [N-1:0]  valid_vec,
  output logic [31:0]   lk_tag,
  output logic [31:0]   lk_dat,
  output logic [31:0]   rd_tag,
  output logic [31:0]   rd_dat
);
  logic [31:0] tag_q [N];
  logic [31:0] dat_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign valid_vec[g] = tag_q[g][VLD_BIT];
    assign lk_match[g]  = entry_hit(tag_q[g], lk_addr);
    assign fl_match[g]  = entry_hit(tag_q[g], fl_addr);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n || clr_all) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end else if (wr_en && wr_slot == SW'(i)) begin
        tag_q[i] <= wr_tag;
        dat_q[i] <= wr_dat;
      end else if (kill[i]) begin
        tag_q[i][VLD_BIT] <= 1'b0;
      end
    end
  end

  always_comb begin
    lk_tag = '0;
    lk_dat = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_grant[i]) begin
        lk_tag = lk_tag | tag_q[i];
        lk_dat = lk_dat | dat_q[i];
      end
    end
  end

  assign rd_tag = rd_ok ? tag_q[rd_idx] : 32'd0;
  assign rd_dat = rd_ok ? dat_q[rd_idx] : 32'd0;

  a_r6_all_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_vec == '0));
  a_r9_single_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill) |=> ($countones($past(valid_vec) & ~valid_vec) <= 1));
  a_r9_kill_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(kill));
endmodule

// File: rtl/pinned_tlb.sv
module pinned_tlb
  import tlbv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [31:0] lk_addr,
  output logic        lk_hit,
  output logic [31:0] lk_pa,
  output logic [31:0] lock_word,
  output logic [31:0] rd_cam,
  output logic [31:0] rd_ram
);
  localparam int SW = $clog2(N);

  if (N != 8 && N != 32) begin : g_bad_count
    $error("pinned_tlb: entry count must be 8 or 32");
  end

  logic [31:0]      stg_tag, stg_dat;
  logic             lock_we, ld_req, fl_req, clr_all;
  logic [IDX_W-1:0] base_q, vict_q, ld_slot;
  logic             ld_ok, rd_ok;
  logic [N-1:0]     lk_match, fl_match, lk_grant, fl_grant, kill, valid_vec;
  logic [31:0]      lk_tag, lk_dat;

  assign lock_we = wr_en && (wr_sel == CMD_LOCK);
  assign ld_req  = wr_en && (wr_sel == CMD_LOAD);
  assign fl_req  = wr_en && (wr_sel == CMD_KILL_ONE);
  assign clr_all = wr_en && (wr_sel == CMD_KILL_ALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_tag <= '0;
      stg_dat <= '0;
    end else if (wr_en) begin
      if (wr_sel == CMD_TAG)  stg_tag <= wr_data;
      if (wr_sel == CMD_DATA) stg_dat <= wr_data;
    end
  end

  tlbv_victim #(.N(N)) u_victim (
    .clk, .rst_n, .lock_we,
    .lock_base(wr_data[BASE_LSB +: LOCK_FW]),
    .lock_vict(wr_data[VICT_LSB +: LOCK_FW]),
    .ld_req, .ld_pres(wr_data[0]), .clr_all,
    .base_q, .vict_q, .ld_ok, .ld_slot
  );

  tlbv_first #(.N(N)) u_pick_lk (.req(lk_match), .grant(lk_grant));
  tlbv_first #(.N(N)) u_pick_fl (.req(fl_match), .grant(fl_grant));

  assign kill  = fl_req ? fl_grant : '0;
  assign rd_ok = vict_q < IDX_W'(N);

  tlbv_store #(.N(N), .SW(SW)) u_store (
    .clk, .rst_n,
    .wr_en(ld_ok), .wr_slot(ld_slot[SW-1:0]),
    .wr_tag(stg_tag), .wr_dat(stg_dat),
    .kill, .clr_all, .lk_addr, .fl_addr(wr_data), .lk_grant,
    .rd_ok, .rd_idx(vict_q[SW-1:0]),
    .lk_match, .fl_match, .valid_vec, .lk_tag, .lk_dat,
    .rd_tag(rd_cam), .rd_dat(rd_ram)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit <= 1'b0;
      lk_pa  <= '0;
    end else begin
      lk_hit <= |lk_match;
      lk_pa  <= (|lk_match) ? xlate(lk_tag, lk_dat, lk_addr) : 32'd0;
    end
  end

  assign lock_word = {16'd0, base_q[LOCK_FW], base_q[LOCK_FW-1:0],
                      vict_q[LOCK_FW], vict_q[LOCK_FW-1:0], 4'd0};

  a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_grant));
  a_r8_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|lk_match) |=> lk_hit);
  a_r8_miss_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(lk_match & valid_vec)) |=> !lk_hit);
endmodule

// File: tb/pinned_tlb_test.sv
`timescale 1ns/1ps
module pinned_tlb_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [31:0] lk_pa, lock_word, rd_cam, rd_ram;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] mtag [N];
  logic [31:0] mdat [N];
  logic [31:0] stag, sdat;
  int mb, mv;

  always #2 clk = ~clk;

  pinned_tlb #(.N(N)) uut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic longint pbytes(input logic [1:0] c);
    case (c)
      2'd0: pbytes = 64'd1 << 20;
      2'd1: pbytes = 64'd1 << 16;
      2'd2: pbytes = 64'd1 << 12;
      default: pbytes = 64'd1 << 24;
    endcase
  endfunction

  function automatic bit m_match(input int i, input logic [31:0] a);
    longint b, t, st, ad;
    b  = pbytes(mtag[i][1:0]);
    t  = {32'd0, mtag[i]};
    ad = {32'd0, a};
    st = t - (t % b);
    m_match = mtag[i][2] && (st <= ad) && (ad < st + b);
  endfunction

  task automatic m_apply(input logic [2:0] s, input logic [31:0] d);
    case (s)
      3'd0: begin mb = int'(d[14:10]); mv = int'(d[8:4]); end
      3'd1: stag = d;
      3'd2: sdat = d;
      3'd3: begin
        if (d[0]) begin
          if (mb < N) begin
            mtag[mb] = stag; mdat[mb] = sdat; mb++; mv = mb;
          end
        end else if (mv < N) begin
          mtag[mv] = stag; mdat[mv] = sdat; mv++;
          if (mv == N) mv = mb;
        end
      end
      3'd4: begin
        for (int i = 0; i < N; i++)
          if (m_match(i, d)) begin mtag[i][2] = 1'b0; break; end
      end
      3'd5: begin
        for (int i = 0; i < N; i++) begin mtag[i] = '0; mdat[i] = '0; end
        mb = 0; mv = 0;
      end
      default: ;
    endcase
  endtask

  task automatic cmd(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_apply(s, d);
  endtask

  task automatic check_state(input string req);
    logic [31:0] lw;
    lw = (32'(mb >> 5 & 1) << 15) | (32'(mb & 31) << 10) |
         (32'(mv >> 5 & 1) << 9) | (32'(mv & 31) << 4);
    chk(req, "lock_word", lock_word, lw);
    chk(req, "rd_cam", rd_cam, (mv < N) ? mtag[mv] : 32'd0);
    chk(req, "rd_ram", rd_ram, (mv < N) ? mdat[mv] : 32'd0);
  endtask

  task automatic check_lookup(input string req, input logic [31:0] a);
    logic        eh;
    logic [31:0] ep;
    longint b;
    eh = 1'b0; ep = '0;
    @(negedge clk);
    lk_addr = a;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      if (m_match(i, a)) begin
        b  = pbytes(mtag[i][1:0]);
        eh = 1'b1;
        ep = 32'(({32'd0, mdat[i]} - ({32'd0, mdat[i]} % b)) + ({32'd0, a} % b));
        break;
      end
    end
    chk(req, "lk_hit", {31'd0, lk_hit}, {31'd0, eh});
    chk(req, "lk_pa", lk_pa, ep);
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] d, input bit pin);
    cmd(3'd1, t);
    cmd(3'd2, d);
    cmd(3'd3, {31'd0, pin});
  endtask

  function automatic logic [31:0] lockv(input int b, input int v);
    lockv = (32'(b & 31) << 10) | (32'(v & 31) << 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CE5_7A11));
    for (int i = 0; i < N; i++) begin mtag[i] = '0; mdat[i] = '0; end
    stag = '0; sdat = '0; mb = 0; mv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_state("R1");
    check_lookup("R1", 32'h1234_5678);

    // R2 lock field placement
    cmd(3'd0, lockv(3, 5));
    check_state("R2");
    chk("R2", "lock raw", lock_word, 32'h0000_0C50);

    // R6 global flush of indices
    cmd(3'd5, 32'd0);
    check_state("R6");

    // R3 / R4 fill all slots, wrap to base
    for (int k = 0; k < N; k++) begin
      load((32'(k) << 24) | 32'h0000_0004 | 32'(k % 4), 32'h8000_0000 + (32'(k) << 24) + 32'h5A, 1'b0);
      check_state("R4");
    end
    chk("R4", "wrapped victim", lock_word, 32'd0);
    for (int k = 0; k < N; k++) begin
      cmd(3'd0, lockv(0, k));
      check_state("R3");
    end
    // R7 lookups inside and just past each page
    for (int k = 0; k < N; k++) begin
      check_lookup("R7", (32'(k) << 24) + 32'($urandom % 32'(pbytes(2'(k % 4)))));
      check_lookup("R7", (32'(k) << 24) + 32'(pbytes(2'(k % 4))));
    end

    // R8 overlap: lowest index wins; invalid never hits
    cmd(3'd5, 32'd0);
    load(32'h4000_1006, 32'h1111_1000, 1'b0);
    load(32'h4000_0007, 32'h2200_0000, 1'b0);
    load(32'h7000_0003, 32'h3300_0000, 1'b0);
    check_lookup("R8", 32'h4000_1234);
    chk("R8", "low index pa", lk_pa, 32'h1111_1234);
    check_lookup("R8", 32'h4000_2000);
    check_lookup("R8", 32'h7000_0010);
    chk("R8", "invalid entry", {31'd0, lk_hit}, 32'd0);

    // R9 flush by address removes only the lowest match
    cmd(3'd4, 32'h4000_1800);
    check_lookup("R9", 32'h4000_1234);
    chk("R9", "fallback pa", lk_pa, 32'h2200_1234);
    cmd(3'd0, lockv(0, 1));
    check_state("R9");
    cmd(3'd0, lockv(0, 0));
    check_state("R9");

    // R5 pinned loads, full refusal
    cmd(3'd5, 32'd0);
    for (int k = 0; k < 3; k++) begin
      load(32'h5000_0005 + (32'(k) << 20), 32'h0A00_0000 + (32'(k) << 20), 1'b1);
      check_state("R5");
    end
    load(32'h5F00_0006, 32'h0B00_0000, 1'b0);
    check_state("R5");
    cmd(3'd0, lockv(7, 7));
    load(32'h6000_0007, 32'h0C00_0000, 1'b1);
    check_state("R5");
    chk("R5", "full base", lock_word, lockv(8, 8));
    load(32'h6100_0007, 32'h0D00_0000, 1'b1);
    check_state("R5");
    load(32'h6200_0007, 32'h0E00_0000, 1'b0);
    check_state("R4");
    cmd(3'd0, lockv(7, 7));
    check_state("R5");
    // R4 wrap to a nonzero base
    cmd(3'd0, lockv(5, 7));
    load(32'h6300_0004, 32'h0F00_0000, 1'b0);
    check_state("R4");
    chk("R4", "wrap to base", lock_word, lockv(5, 5));

    // R10 unused codes
    cmd(3'd6, 32'hFFFF_FFFF);
    check_state("R10");
    cmd(3'd7, 32'h0000_7FF1);
    check_state("R10");
    check_lookup("R10", 32'h5000_0010);

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op;
      op = int'($urandom % 100);
      if (op < 40) begin
        load(32'h4000_0000 | ($urandom & 32'h03FF_F000) | 32'($urandom % 8),
             $urandom, ($urandom % 5) == 0);
        check_state("R3");
      end else if (op < 80) begin
        check_lookup("R7", 32'h4000_0000 | ($urandom & 32'h03FF_FFFF));
      end else if (op < 88) begin
        cmd(3'd4, 32'h4000_0000 | ($urandom & 32'h03FF_FFFF));
        check_state("R9");
      end else if (op < 97) begin
        cmd(3'd0, lockv(int'($urandom % 10), int'($urandom % 10)));
        check_state("R2");
      end else begin
        cmd(3'd5, 32'd0);
        check_state("R6");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule